// File: doc/BRIEF.md
# Bus transaction timeout monitor

The monitor sits beside a processor-side bus and turns a missing response into a bus error. Each transfer starts with a read or write strobe. At that moment the monitor also captures whether the access goes to the external bus bridge. An internal access must be acknowledged within a fixed window of cycles. If it is not, the monitor raises a one-cycle bus error. An external access is timed by the bridge, so this monitor never flags it for slowness.

The class and the direction of an access are captured at the start strobe. They are held until the transfer ends. The external indication can drop before the acknowledge arrives without changing how the transfer is treated. An acknowledge that lands in the same cycle as the counter reaches zero completes the transfer cleanly.

A slave error response is passed on as a bus error in the same cycle. A sticky status record keeps the cause and the direction of the latest error for debug.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset the outputs are low: `bus_err_o`, `stat_valid_o`, `stat_tmo_o` and `stat_wr_o`.
- R2: Call the cycle after the start-strobe clock edge cycle 0. An internal transfer acknowledged in any cycle from 0 to 15 produces no bus error.
- R3: An internal transfer with no acknowledge and no slave error drives `bus_err_o` high in cycle 15, and in no other cycle.
- R4: The class is latched from `req_ext_i` at the start strobe (1 = external). A transfer latched as external never raises a timeout error, whatever its latency and whatever `req_ext_i` does later.
- R5: An acknowledge in cycle 15, the cycle in which the internal counter is at zero, counts as success and raises no error.
- R6: In the cycle after an acknowledge has completed a transfer, `bus_err_o` is low.
- R7: `err_i` high while a transfer is pending drives `bus_err_o` high in that same cycle and ends the transfer.
- R8: A start strobe while a transfer is pending restarts the window, so the timeout lands in cycle 15 counted from the newest strobe.
- R9: After each bus error, from the next cycle on, `stat_valid_o` is 1. `stat_tmo_o` is 1 for a timeout and 0 for a slave error. `stat_wr_o` is 1 for a write and 0 for a read. The values hold until the next error.
- R10: `bus_err_o` is never high for two cycles in a row without a new start strobe in between. `err_i` or `ack_i` with no transfer pending has no effect on `bus_err_o` or the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_rd_i | input | 1 | Read start strobe |
| req_wr_i | input | 1 | Write start strobe (wins if both strobes are high) |
| req_ext_i | input | 1 | Access routed to the external bridge, sampled at the strobe |
| ack_i | input | 1 | Slave acknowledge |
| err_i | input | 1 | Slave error response |
| bus_err_o | output | 1 | Bus error pulse |
| stat_valid_o | output | 1 | At least one error has been recorded |
| stat_tmo_o | output | 1 | The last error was a timeout (1) or a slave error (0) |
| stat_wr_o | output | 1 | The last failing access was a write (1) or a read (0) |

## Verification
A wrong latched class shows at the ports as an error in cycle 15 of an external transfer once `req_ext_i` has dropped. It can also show as a missing error on an internal one.

A counter that is off by one moves the error pulse one cycle early or late. It also causes a false error on an acknowledge that arrives exactly at zero, all within 16 cycles of the strobe.

Pending state that is not cleared shows as an error in the cycle after completion, or as a response to a stray `err_i` while idle. The bench sweeps every latency from 0 to 20 cycles for each class and direction, with the class indication dropped after the strobe. It compares `bus_err_o` in every cycle.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;
  localparam int unsigned TMO_LIMIT = 15;

  typedef struct packed {
    logic valid;
    logic tmo;
    logic wr;
  } err_stat_t;
endpackage

// File: rtl/bus_tmo_timer.sv
module bus_tmo_timer #(
  parameter int unsigned LIMIT = bus_tmo_pkg::TMO_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ext_i,
  input  logic wr_i,
  input  logic ack_i,
  input  logic err_i,
  output logic pend_o,
  output logic ext_o,
  output logic wr_o,
  output logic zero_o,
  output logic tmo_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, ext_q, wr_q;
  logic             zero, tmo, done;

  assign zero = (cnt_q == '0);
  // ack and slave error both beat the timeout in the same cycle
  assign tmo  = pend_q & ~ext_q & zero & ~ack_i & ~err_i;
  assign done = pend_q & (ack_i | err_i | tmo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      ext_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CNT_W'(LIMIT);
      ext_q  <= ext_i;
      wr_q   <= wr_i;
    end else if (done) begin
      pend_q <= 1'b0;
    end else if (pend_q && !zero) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign ext_o  = ext_q;
  assign wr_o   = wr_q;
  assign zero_o = zero;
  assign tmo_o  = tmo;

  assert_cnt_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pend_q && cnt_q == CNT_W'(LIMIT)));
  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start_i && !done && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_class_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start_i) |=> $stable(ext_q));
  assert_ack_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ack_i && !start_i) |=> !pend_q);
endmodule

// File: rtl/bus_tmo_status.sv
module bus_tmo_status
  import bus_tmo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      evt_i,
  input  logic      tmo_i,
  input  logic      wr_i,
  output err_stat_t stat_o
);
  err_stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (evt_i) begin
      stat_q.valid <= 1'b1;
      stat_q.tmo   <= tmo_i;
      stat_q.wr    <= wr_i;
    end
  end

  assign stat_o = stat_q;

  assert_stat_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (stat_q.valid && stat_q.tmo == $past(tmo_i) && stat_q.wr == $past(wr_i)));
  assert_stat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(stat_q));
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import bus_tmo_pkg::*;
#(
  parameter int unsigned LIMIT = TMO_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_rd_i,
  input  logic req_wr_i,
  input  logic req_ext_i,
  input  logic ack_i,
  input  logic err_i,
  output logic bus_err_o,
  output logic stat_valid_o,
  output logic stat_tmo_o,
  output logic stat_wr_o
);
  logic      start, pend, ext_q, wr_q, zero, tmo;
  err_stat_t stat;

  assign start = req_rd_i | req_wr_i;

  bus_tmo_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ext_i   (req_ext_i),
    .wr_i    (req_wr_i),
    .ack_i   (ack_i),
    .err_i   (err_i),
    .pend_o  (pend),
    .ext_o   (ext_q),
    .wr_o    (wr_q),
    .zero_o  (zero),
    .tmo_o   (tmo)
  );

  assign bus_err_o = (pend & err_i) | tmo;

  bus_tmo_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (bus_err_o),
    .tmo_i  (tmo),
    .wr_i   (wr_q),
    .stat_o (stat)
  );

  assign stat_valid_o = stat.valid;
  assign stat_tmo_o   = stat.tmo;
  assign stat_wr_o    = stat.wr;

  assert_ext_no_tmo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_q && !err_i) |-> !bus_err_o);
  assert_ack_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && zero && ack_i && !err_i) |-> !bus_err_o);
  assert_no_late_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && ack_i && !start) |=> !bus_err_o);
  assert_slave_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && err_i) |-> bus_err_o);
  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o && !start) |=> !bus_err_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |-> !bus_err_o);
endmodule

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd, wr, ext, ack, err;
  logic bus_err, st_valid, st_tmo, st_wr;
  int checks = 0;
  int fails  = 0;
  logic e_valid = 1'b0, e_tmo = 1'b0, e_wr = 1'b0;

  always #4 clk = ~clk;

  bus_timeout_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_rd_i(rd), .req_wr_i(wr), .req_ext_i(ext),
    .ack_i(ack), .err_i(err), .bus_err_o(bus_err), .stat_valid_o(st_valid),
    .stat_tmo_o(st_tmo), .stat_wr_o(st_wr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_stat(input string req);
    chk({req, " valid"}, st_valid, e_valid);
    chk({req, " tmo"}, st_tmo, e_tmo);
    chk({req, " wr"}, st_wr, e_wr);
  endtask

  // start strobe, then ack in cycle lat; class input flipped after the strobe
  task automatic xfer(input logic is_ext, input logic is_wr, input int lat);
    logic exp;
    @(negedge clk);
    rd = ~is_wr; wr = is_wr; ext = is_ext;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; ext = ~is_ext;
    for (int k = 0; k <= lat + 1; k++) begin
      ack = (k == lat);
      #1;
      exp = !is_ext && lat > 15 && k == 15;
      chk(k == 15 ? "R5/R3" : (k == lat + 1 ? "R6" : (is_ext ? "R4" : "R2/R3")), bus_err, exp);
      if (exp) begin e_valid = 1'b1; e_tmo = 1'b1; e_wr = is_wr; end
      @(negedge clk);
    end
    ack = 1'b0; ext = 1'b0;
    #1;
    chk_stat("R9");
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    rd = 0; wr = 0; ext = 0; ack = 0; err = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 err", bus_err, 1'b0);
    chk_stat("R1");
    rst_n = 1'b1;

    // near-exhaustive latency sweep
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 2; d++)
        for (int l = 0; l <= 20; l++)
          xfer(c[0], d[0], l);
    xfer(1'b1, 1'b0, 40);

    // R7 slave error, internal read and external write
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      rd = c[0] ? 1'b0 : 1'b1; wr = c[0]; ext = c[0];
      @(negedge clk);
      rd = 0; wr = 0; ext = 0;
      repeat (3) @(negedge clk);
      err = 1'b1; #1;
      chk("R7 passthrough", bus_err, 1'b1);
      e_valid = 1'b1; e_tmo = 1'b0; e_wr = c[0];
      @(negedge clk);
      err = 1'b0; #1;
      chk("R10 pulse", bus_err, 1'b0);
      chk_stat("R9 slave");
      repeat (20) begin
        @(negedge clk); #1;
        chk("R7 ended", bus_err, 1'b0);
      end
    end

    // R10 stray err/ack while idle
    @(negedge clk);
    err = 1'b1; ack = 1'b1; #1;
    chk("R10 idle err", bus_err, 1'b0);
    @(negedge clk);
    err = 1'b0; ack = 1'b0; #1;
    chk_stat("R10 idle");

    // R8 restart: second strobe in cycle 10 of the first
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    repeat (10) @(negedge clk);
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    for (int k = 0; k <= 17; k++) begin
      #1;
      chk("R8 restart", bus_err, k == 15);
      @(negedge clk);
    end
    e_valid = 1'b1; e_tmo = 1'b1; e_wr = 1'b1;
    #1;
    chk_stat("R8/R9");

    finish_sim();
  end
endmodule